// File: doc/BRIEF.md
# Full-Speed Bus Turnaround Timeout Timer

After a full-speed packet ends, the link expects the other side to start its reply within a bounded window. This block times that window. It counts clocks of the transceiver clock, which runs at four times the bit rate, so one clock is a quarter of a bit time. Counting starts at a start strobe given at the end of a packet. If a response strobe arrives first, the count stops quietly. If no response arrives, a one-cycle timeout pulse is raised.

The nominal window is 18 bit times, which is 72 clocks. A 3-bit calibration value adds 0 to 7 more clocks to that window. This covers the time a given transceiver takes to report line activity. The block takes the calibration value at the start strobe and keeps it fixed for the rest of that measurement. A start strobe that arrives while a measurement is running restarts the count with the calibration value present at that moment.

Top module: `fs_turnaround_timer`

## Requirements
- R1: After reset, busy_o is 0 and timeout_o is 0.
- R2: A start_i high at a clock edge sets busy_o to 1 after that edge, with the count at zero, and no timeout_o appears after that edge.
- R3: With a calibration of 0 and no response, timeout_o goes to 1 after the 72nd clock edge that follows the start edge, and not after any earlier edge.
- R4: With calibration value c (0 to 7, unsigned), the timeout occurs after edge 72 + c counted from the start edge.
- R5: timeout_o stays high for exactly one cycle. busy_o falls after the same edge at which timeout_o rises, and no further pulse follows until a new start.
- R6: A resp_i high while busy, and before expiry, clears busy_o after that edge. No timeout_o is produced for that measurement.
- R7: If resp_i is high at the edge that would otherwise expire the count, the response takes priority and no timeout_o is produced.
- R8: cal_i is sampled only at the start edge. Changes to cal_i during a measurement do not move the timeout edge.
- R9: A start_i while busy restarts the count from zero and samples cal_i again. The timeout then comes 72 + new calibration edges after the restart edge.
- R10: A resp_i while idle has no effect: busy_o and timeout_o stay 0, and the next measurement is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_phy | input | 1 | Transceiver clock, four per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | End-of-packet strobe; starts or restarts a measurement |
| resp_i | input | 1 | Response-start strobe from the line receiver |
| cal_i | input | CAL_W (3) | Extra quarter-bit clocks added to the window |
| timeout_o | output | 1 | One-cycle pulse when the window expires |
| busy_o | output | 1 | High while a measurement is running |

## Verification
The expiry edge is measured exactly, in cycles from the start edge, for calibration values 0, 3 and 7. These runs tell a correct adder apart from one that drops or offsets the calibration, and they would catch an off-by-one in the compare. A response is placed well before expiry and then exactly on the expiry edge, which separates a correct priority from a design that lets the timeout win the tie. Changing cal_i during a measurement, restarting a measurement mid-window, and sending a response while idle show whether the calibration is latched, whether a restart clears the count, and whether idle responses are ignored.

// File: rtl/ito_pkg.sv
package ito_pkg;

   // Window length in transceiver clocks for a given calibration value.
   function automatic int unsigned window_clocks(input int unsigned base_bits,
                                                 input int unsigned clk_per_bit,
                                                 input int unsigned cal);
      return base_bits * clk_per_bit + cal;
   endfunction

endpackage

// File: rtl/ito_limit.sv
module ito_limit #(
   parameter int unsigned BASE_BITS   = 18,
   parameter int unsigned CLK_PER_BIT = 4,
   parameter int unsigned CAL_W       = 3,
   parameter int unsigned CNT_W       = 7,
   parameter bit          USE_TABLE   = 1'b0
) (
   input  logic [CAL_W-1:0] cal,
   output logic [CNT_W-1:0] limit
);
   import ito_pkg::*;

   localparam int unsigned BASE_CLK = BASE_BITS * CLK_PER_BIT;
   localparam int unsigned NCAL     = 1 << CAL_W;

   generate
      if (USE_TABLE) begin : g_table
         logic [CNT_W-1:0] tbl [NCAL];
         for (genvar i = 0; i < NCAL; i++) begin : g_ent
            assign tbl[i] = CNT_W'(window_clocks(BASE_BITS, CLK_PER_BIT, i));
         end
         assign limit = tbl[cal];
      end else begin : g_adder
         assign limit = CNT_W'(BASE_CLK) + CNT_W'(cal);
      end
   endgenerate
endmodule

// File: rtl/ito_counter.sv
module ito_counter #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             busy,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (busy)     cnt_q <= cnt_q + 1'b1;
      else               cnt_q <= '0;
   end

   // The edge that would bring the count to the limit is the expiry edge.
   assign expire = busy && (cnt_q == limit - 1'b1);

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q < limit)); // R3
   AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !restart) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/ito_ctrl.sv
module ito_ctrl #(
   parameter int unsigned CAL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             resp,
   input  logic             expire,
   input  logic [CAL_W-1:0] cal_in,
   output logic [CAL_W-1:0] cal_q,
   output logic             busy_q,
   output logic             timeout_q
);
   // Priority: start over response over expiry.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         timeout_q <= 1'b0;
         cal_q     <= '0;
      end else begin
         timeout_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            cal_q  <= cal_in;
         end else if (resp) begin
            busy_q <= 1'b0;
         end else if (expire) begin
            busy_q    <= 1'b0;
            timeout_q <= 1'b1;
         end
      end
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy_q && !timeout_q)); // R2
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_q |=> !timeout_q); // R5
   AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_q |-> !busy_q); // R5
   AST_RESP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && resp && !start) |=> (!busy_q && !timeout_q)); // R6
   AST_RESP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (resp && !start) |=> !timeout_q); // R7
   AST_CAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(cal_q)); // R8
   AST_IDLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && resp && !start) |=> (!busy_q && !timeout_q)); // R10
endmodule

// File: rtl/fs_turnaround_timer.sv
module fs_turnaround_timer #(
   parameter int unsigned BASE_BITS   = 18,
   parameter int unsigned CLK_PER_BIT = 4,
   parameter int unsigned CAL_W       = 3,
   parameter bit          USE_TABLE   = 1'b0
) (
   input  logic             clk_phy,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             resp_i,
   input  logic [CAL_W-1:0] cal_i,
   output logic             timeout_o,
   output logic             busy_o
);
   localparam int unsigned LIMIT_MAX = BASE_BITS * CLK_PER_BIT + (1 << CAL_W) - 1;
   localparam int unsigned CNT_W     = $clog2(LIMIT_MAX + 1);

   initial begin
      assert (BASE_BITS >= 16 && BASE_BITS <= 18)
         else $fatal(1, "BASE_BITS outside the full-speed window");
      assert (CLK_PER_BIT >= 1) else $fatal(1, "CLK_PER_BIT must be nonzero");
      assert (CAL_W >= 1 && CAL_W <= 6) else $fatal(1, "CAL_W out of range");
   end

   logic [CAL_W-1:0] cal_q;
   logic [CNT_W-1:0] limit;
   logic             expire;
   logic             busy_q;
   logic             timeout_q;

   ito_limit #(
      .BASE_BITS(BASE_BITS), .CLK_PER_BIT(CLK_PER_BIT),
      .CAL_W(CAL_W), .CNT_W(CNT_W), .USE_TABLE(USE_TABLE)
   ) u_limit (
      .cal(cal_q), .limit(limit)
   );

   ito_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk_phy), .rst_n(rst_n), .restart(start_i),
      .busy(busy_q), .limit(limit), .expire(expire)
   );

   ito_ctrl #(.CAL_W(CAL_W)) u_ctrl (
      .clk(clk_phy), .rst_n(rst_n), .start(start_i), .resp(resp_i),
      .expire(expire), .cal_in(cal_i), .cal_q(cal_q),
      .busy_q(busy_q), .timeout_q(timeout_q)
   );

   assign timeout_o = timeout_q;
   assign busy_o    = busy_q;

   AST_NO_LATE_TIMEOUT: assert property (@(posedge clk_phy) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(busy_o)); // R4
endmodule

// File: tb/fs_turnaround_timer_tb.sv
module fs_turnaround_timer_tb;
   logic clk_phy = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic resp_i = 1'b0;
   logic [2:0] cal_i = '0;
   logic timeout_o, busy_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk_phy = ~clk_phy;

   fs_turnaround_timer u_dut (
      .clk_phy(clk_phy), .rst_n(rst_n), .start_i(start_i), .resp_i(resp_i),
      .cal_i(cal_i), .timeout_o(timeout_o), .busy_o(busy_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Start strobe across one edge (edge 0); returns at the negedge after it.
   task automatic kick(input logic [2:0] c);
      @(negedge clk_phy);
      start_i = 1'b1; cal_i = c;
      @(negedge clk_phy);
      start_i = 1'b0;
   endtask

   // Edges since edge 0 until timeout_o is seen high.
   task automatic measure(output int n);
      n = 0;
      while (!timeout_o && n < 200) begin
         @(negedge clk_phy);
         n++;
      end
   endtask

   task automatic t_reset();
      check("R1 busy", busy_o, 0);
      check("R1 timeout", timeout_o, 0);
   endtask

   task automatic t_window(input logic [2:0] c, input string req);
      int n;
      kick(c);
      check("R2 busy after start", busy_o, 1);
      check("R2 no timeout", timeout_o, 0);
      measure(n);
      check(req, n, 72 + c);
      check("R5 busy low at pulse", busy_o, 0);
      @(negedge clk_phy);
      check("R5 pulse width", timeout_o, 0);
      repeat (90) @(negedge clk_phy);
      check("R5 no second pulse", timeout_o, 0);
   endtask

   task automatic t_resp_early();
      int seen = 0;
      kick(3'd5);
      repeat (30) @(negedge clk_phy);
      resp_i = 1'b1;
      @(negedge clk_phy);
      resp_i = 1'b0;
      check("R6 busy cleared", busy_o, 0);
      for (int i = 0; i < 100; i++) begin
         if (timeout_o) seen = 1;
         @(negedge clk_phy);
      end
      check("R6 no timeout", seen, 0);
   endtask

   task automatic t_resp_tie();
      int seen = 0;
      kick(3'd0);
      repeat (71) @(negedge clk_phy);  // after edge 71
      resp_i = 1'b1;                   // high at edge 72
      @(negedge clk_phy);
      resp_i = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (timeout_o) seen = 1;
         @(negedge clk_phy);
      end
      check("R7 response wins tie", seen, 0);
      check("R7 idle after", busy_o, 0);
   endtask

   task automatic t_cal_change();
      int n;
      kick(3'd2);
      cal_i = 3'd7;
      measure(n);
      check("R8 calibration latched", n, 74);
      repeat (3) @(negedge clk_phy);
   endtask

   task automatic t_restart();
      int n;
      kick(3'd7);
      repeat (40) @(negedge clk_phy);
      check("R9 still busy", busy_o, 1);
      kick(3'd1);
      measure(n);
      check("R9 restart window", n, 73);
      repeat (3) @(negedge clk_phy);
   endtask

   task automatic t_idle_resp();
      int n;
      @(negedge clk_phy);
      resp_i = 1'b1;
      @(negedge clk_phy);
      resp_i = 1'b0;
      check("R10 busy stays low", busy_o, 0);
      check("R10 no timeout", timeout_o, 0);
      kick(3'd0);
      measure(n);
      check("R10 next window", n, 72);
      repeat (3) @(negedge clk_phy);
   endtask

   initial begin
      repeat (3) @(negedge clk_phy);
      rst_n = 1'b1;
      @(negedge clk_phy);
      t_reset();
      t_window(3'd0, "R3 base window");
      t_window(3'd3, "R4 cal 3 window");
      t_window(3'd7, "R4 cal 7 window");
      t_resp_early();
      t_resp_tie();
      t_cal_change();
      t_restart();
      t_idle_resp();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk_phy);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule